// File: doc/BRIEF.md
# Banked floating-point register file

This block holds the floating-point operand storage of a processor core: thirty-two 32-bit entries organised as two banks of sixteen. It also holds the mode control register that steers how register numbers are mapped, and a separate 32-bit communication register that carries values between the integer and floating-point sides. Instruction register numbers are four bits wide. A bank-select bit in the mode register decides which physical bank those numbers reach. An extended-bank flag on the single-word ports reaches the other bank.

Two pairs of ports serve the datapath. One pair moves single 32-bit words. The other pair moves 64-bit values as two consecutive entries. A transfer-size bit in the mode register turns an odd pair number into a reference to the matching even pair of the opposite bank. A toggle input flips one chosen mode bit in one cycle. Reads are combinational. Writes, mode updates and communication register loads take effect on the rising clock edge. A synchronous active-high reset clears all storage.

Top module: `fpreg_bank_top`

## Requirements
- R1: While reset is high, on a rising edge every one of the 32 entries and the communication register become zero, and the mode register is loaded with MODE_INIT masked to bits 21:0. The default MODE_INIT is 0x0004_0001.
- R2: A single-word access with the extended flag at 0 reaches physical entry {bank, idx}, where bank is mode bit 21. Index n therefore reaches entry n when bank is 0 and entry n+16 when bank is 1.
- R3: A single-word access with the extended flag at 1 reaches physical entry {~bank, idx}, which is the same index in the bank that is not selected.
- R4: When mode bit 20 (transfer size) is 0, pair number n covers physical entries base and base+1, with base = {bank, n[3:1], 0}. An odd n therefore rounds down to the even pair.
- R5: When mode bit 20 is 1 and pair number n is odd, the pair covers base = {~bank, n[3:1], 0}, which is the even pair of the opposite bank. An even n behaves as in R4.
- R6: Pair data bits 63:32 belong to the even entry base, which a memory transfer places at byte offset +4. Bits 31:0 belong to entry base+1, which sits at offset +0. This holds for both the pair read port and the pair write port.
- R7: Read ports are combinational. A write becomes visible on the read port only after the rising edge that performs it. In the cycle of the write, the read port still shows the old value.
- R8: When a single-word write and a pair write in the same cycle hit the same physical entry, the entry takes the pair write's word.
- R9: A mode register write stores the written value with bits 31:22 forced to zero. Those bits always read back as zero.
- R10: The toggle input with tog_sel 0 inverts mode bit 20 (size), with 1 inverts bit 19 (precision), with 2 inverts bit 21 (bank), and with 3 changes nothing. Two identical toggles restore the earlier value.
- R11: When a mode write and a toggle occur in the same cycle, the mode write alone takes effect.
- R12: The communication register loads comm_wdata on an edge where comm_we is high and holds its value on every other edge, whatever the other ports do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_we | input | 1 | Single-word write enable |
| sw_idx | input | 4 | Single-word write register number |
| sw_ext | input | 1 | Single-word write reaches the non-selected bank |
| sw_data | input | 32 | Single-word write data |
| sr_idx | input | 4 | Single-word read register number |
| sr_ext | input | 1 | Single-word read reaches the non-selected bank |
| sr_data | output | 32 | Single-word read data |
| pw_we | input | 1 | Pair write enable |
| pw_idx | input | 4 | Pair write register number |
| pw_data | input | 64 | Pair write data, even entry in bits 63:32 |
| pr_idx | input | 4 | Pair read register number |
| pr_data | output | 64 | Pair read data, even entry in bits 63:32 |
| mode_we | input | 1 | Mode register write enable |
| mode_wdata | input | 32 | Mode register write data |
| tog_en | input | 1 | Mode bit toggle strobe |
| tog_sel | input | 2 | Toggled bit: 0 size, 1 precision, 2 bank, 3 none |
| mode_q | output | 32 | Mode register contents |
| comm_we | input | 1 | Communication register write enable |
| comm_wdata | input | 32 | Communication register write data |
| comm_q | output | 32 | Communication register contents |

## Verification
The bench uses the default parameters: 32-bit words, sixteen entries per bank and the initial mode 0x0004_0001. With these, both banks, all sixteen pair numbers and the odd-number redirect into the opposite bank can each be reached within a few cycles. Random mode writes and toggles change the bank and size bits while writes are in flight. This exercises every combination of remap bits against same-cycle collisions between the single-word port and the pair port. The precision, rounding and denormal fields show up only in the mode readback, and their default values make a lost or stray bit easy to see.

// File: rtl/fpr_pkg.sv
package fpr_pkg;
  // Mode register field positions; the remap logic depends on SIZE_BIT and BANK_BIT.
  localparam int RND_LSB    = 0;
  localparam int RND_MSB    = 1;
  localparam int DENORM_BIT = 18;
  localparam int PREC_BIT   = 19;
  localparam int SIZE_BIT   = 20;
  localparam int BANK_BIT   = 21;
  localparam int MODE_USED  = BANK_BIT + 1;

  typedef enum logic [1:0] {
    TOG_SIZE = 2'd0,
    TOG_PREC = 2'd1,
    TOG_BANK = 2'd2,
    TOG_NONE = 2'd3
  } tog_sel_e;
endpackage

// File: rtl/fpr_addr_map.sv
module fpr_addr_map #(
  parameter int IDX_W = 4
) (
  input  logic             bank_i,
  input  logic             size_i,
  input  logic             ext_i,
  input  logic             pair_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [IDX_W:0]   phys_o
);
  logic             ext_eff;
  logic [IDX_W-1:0] low_idx;

  // Pair accesses redirect odd numbers to the opposite bank only in 64-bit transfer mode.
  always_comb begin
    if (pair_i) begin
      ext_eff = size_i & idx_i[0];
      low_idx = {idx_i[IDX_W-1:1], 1'b0};
    end else begin
      ext_eff = ext_i;
      low_idx = idx_i;
    end
    phys_o = {bank_i ^ ext_eff, low_idx};
  end
endmodule

// File: rtl/fpr_mode_reg.sv
module fpr_mode_reg
  import fpr_pkg::*;
#(
  parameter int              W    = 32,
  parameter logic [W-1:0]    INIT = W'(32'h0004_0001)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         tog_en,
  input  logic [1:0]   tog_sel,
  output logic [W-1:0] mode_q,
  output logic         bank_o,
  output logic         size_o
);
  localparam logic [W-1:0] MASK = {{(W-MODE_USED){1'b0}}, {MODE_USED{1'b1}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= INIT & MASK;
    end else if (wr_en) begin
      mode_q <= wr_data & MASK;
    end else if (tog_en) begin
      case (tog_sel_e'(tog_sel))
        TOG_SIZE: mode_q[SIZE_BIT] <= ~mode_q[SIZE_BIT];
        TOG_PREC: mode_q[PREC_BIT] <= ~mode_q[PREC_BIT];
        TOG_BANK: mode_q[BANK_BIT] <= ~mode_q[BANK_BIT];
        default:  mode_q <= mode_q;
      endcase
    end
  end

  assign bank_o = mode_q[BANK_BIT];
  assign size_o = mode_q[SIZE_BIT];

  AST_MODE_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    mode_q[W-1:MODE_USED] == '0); // R9

  AST_WRITE_BEATS_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> mode_q == ($past(wr_data) & MASK)); // R11

  AST_BANK_FLIPS: assert property (@(posedge clk) disable iff (rst)
    (tog_en && !wr_en && tog_sel == 2'd2) |=> mode_q[BANK_BIT] != $past(mode_q[BANK_BIT])); // R10

  AST_MODE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && (!tog_en || tog_sel == 2'd3)) |=> $stable(mode_q)); // R10
endmodule

// File: rtl/fpr_storage.sv
module fpr_storage #(
  parameter int W   = 32,
  parameter int NUM = 32,
  localparam int AW = $clog2(NUM)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           sw_we,
  input  logic [AW-1:0]  sw_addr,
  input  logic [W-1:0]   sw_data,
  input  logic           pw_we,
  input  logic [AW-1:0]  pw_base,
  input  logic [2*W-1:0] pw_data,
  input  logic [AW-1:0]  sr_addr,
  output logic [W-1:0]   sr_data,
  input  logic [AW-1:0]  pr_base,
  output logic [2*W-1:0] pr_data
);
  logic [W-1:0]   mem_q [NUM];
  logic [W-1:0]   nxt   [NUM];
  logic [NUM-1:0] pair_hit;
  logic [NUM-1:0] single_hit;

  // Per-entry write decode; the pair port takes precedence on a shared entry.
  for (genvar g = 0; g < NUM; g++) begin : g_entry
    localparam logic [AW-1:0] BASE = AW'((g / 2) * 2);
    assign pair_hit[g]   = pw_we && (pw_base == BASE);
    assign single_hit[g] = sw_we && (sw_addr == AW'(g));
    if (g % 2 == 0) begin : g_even
      assign nxt[g] = pair_hit[g] ? pw_data[2*W-1:W] : sw_data;
    end else begin : g_odd
      assign nxt[g] = pair_hit[g] ? pw_data[W-1:0] : sw_data;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM; i++) begin
      if (rst) begin
        mem_q[i] <= '0;
      end else if (pair_hit[i] || single_hit[i]) begin
        mem_q[i] <= nxt[i];
      end
    end
  end

  assign sr_data = mem_q[sr_addr];
  assign pr_data = {mem_q[pr_base], mem_q[pr_base | AW'(1)]};

  AST_PAIR_WINS: assert property (@(posedge clk) disable iff (rst)
    (pw_we && sw_we && sw_addr == pw_base) |=> mem_q[$past(pw_base)] == $past(pw_data[2*W-1:W])); // R8

  AST_PAIR_LOW_WORD: assert property (@(posedge clk) disable iff (rst)
    pw_we |=> mem_q[$past(pw_base) | AW'(1)] == $past(pw_data[W-1:0])); // R6

  AST_SINGLE_LANDS: assert property (@(posedge clk) disable iff (rst)
    (sw_we && !pw_we) |=> mem_q[$past(sw_addr)] == $past(sw_data)); // R7
endmodule

// File: rtl/fpreg_bank_top.sv
module fpreg_bank_top
  import fpr_pkg::*;
#(
  parameter int                 DATA_W       = 32,
  parameter int                 BANK_ENTRIES = 16,
  parameter logic [DATA_W-1:0]  MODE_INIT    = DATA_W'(32'h0004_0001),
  localparam int                IDX_W        = $clog2(BANK_ENTRIES)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sw_we,
  input  logic [IDX_W-1:0]    sw_idx,
  input  logic                sw_ext,
  input  logic [DATA_W-1:0]   sw_data,
  input  logic [IDX_W-1:0]    sr_idx,
  input  logic                sr_ext,
  output logic [DATA_W-1:0]   sr_data,
  input  logic                pw_we,
  input  logic [IDX_W-1:0]    pw_idx,
  input  logic [2*DATA_W-1:0] pw_data,
  input  logic [IDX_W-1:0]    pr_idx,
  output logic [2*DATA_W-1:0] pr_data,
  input  logic                mode_we,
  input  logic [DATA_W-1:0]   mode_wdata,
  input  logic                tog_en,
  input  logic [1:0]          tog_sel,
  output logic [DATA_W-1:0]   mode_q,
  input  logic                comm_we,
  input  logic [DATA_W-1:0]   comm_wdata,
  output logic [DATA_W-1:0]   comm_q
);
  localparam int NUM   = 2 * BANK_ENTRIES;
  localparam int AW    = IDX_W + 1;
  localparam int PORTS = 4;  // 0 single write, 1 single read, 2 pair write, 3 pair read

  logic              bank;
  logic              size;
  logic [IDX_W-1:0]  map_idx  [PORTS];
  logic              map_ext  [PORTS];
  logic [AW-1:0]     map_phys [PORTS];

  fpr_mode_reg #(
    .W    (DATA_W),
    .INIT (MODE_INIT)
  ) u_mode (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (mode_we),
    .wr_data (mode_wdata),
    .tog_en  (tog_en),
    .tog_sel (tog_sel),
    .mode_q  (mode_q),
    .bank_o  (bank),
    .size_o  (size)
  );

  assign map_idx[0] = sw_idx;
  assign map_ext[0] = sw_ext;
  assign map_idx[1] = sr_idx;
  assign map_ext[1] = sr_ext;
  assign map_idx[2] = pw_idx;
  assign map_ext[2] = 1'b0;
  assign map_idx[3] = pr_idx;
  assign map_ext[3] = 1'b0;

  for (genvar p = 0; p < PORTS; p++) begin : g_map
    fpr_addr_map #(
      .IDX_W (IDX_W)
    ) u_map (
      .bank_i (bank),
      .size_i (size),
      .ext_i  (map_ext[p]),
      .pair_i ((p >= 2) ? 1'b1 : 1'b0),
      .idx_i  (map_idx[p]),
      .phys_o (map_phys[p])
    );
  end

  fpr_storage #(
    .W   (DATA_W),
    .NUM (NUM)
  ) u_store (
    .clk     (clk),
    .rst     (rst),
    .sw_we   (sw_we),
    .sw_addr (map_phys[0]),
    .sw_data (sw_data),
    .pw_we   (pw_we),
    .pw_base (map_phys[2]),
    .pw_data (pw_data),
    .sr_addr (map_phys[1]),
    .sr_data (sr_data),
    .pr_base (map_phys[3]),
    .pr_data (pr_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      comm_q <= '0;
    end else if (comm_we) begin
      comm_q <= comm_wdata;
    end
  end

  AST_COMM_LOAD: assert property (@(posedge clk) disable iff (rst)
    comm_we |=> comm_q == $past(comm_wdata)); // R12

  AST_COMM_HOLD: assert property (@(posedge clk) disable iff (rst)
    !comm_we |=> $stable(comm_q)); // R12
endmodule

// File: tb/fpreg_bank_top_test.sv
`timescale 1ns/1ps
module fpreg_bank_top_test;
  localparam logic [31:0] MASK = 32'h003F_FFFF;

  logic        clk = 1'b0;
  logic        rst;
  logic        sw_we, sw_ext, sr_ext, pw_we, mode_we, tog_en, comm_we;
  logic [3:0]  sw_idx, sr_idx, pw_idx, pr_idx;
  logic [1:0]  tog_sel;
  logic [31:0] sw_data, mode_wdata, comm_wdata;
  logic [63:0] pw_data;
  logic [31:0] sr_data, mode_q, comm_q;
  logic [63:0] pr_data;

  int checks = 0;
  int errors = 0;
  bit run_cmp = 1'b0;
  bit done = 1'b0;

  logic [31:0] m_reg [32];
  logic [31:0] m_mode;
  logic [31:0] m_comm;

  always #2.5 clk = ~clk;

  fpreg_bank_top uut (
    .clk(clk), .rst(rst),
    .sw_we(sw_we), .sw_idx(sw_idx), .sw_ext(sw_ext), .sw_data(sw_data),
    .sr_idx(sr_idx), .sr_ext(sr_ext), .sr_data(sr_data),
    .pw_we(pw_we), .pw_idx(pw_idx), .pw_data(pw_data),
    .pr_idx(pr_idx), .pr_data(pr_data),
    .mode_we(mode_we), .mode_wdata(mode_wdata), .tog_en(tog_en), .tog_sel(tog_sel),
    .mode_q(mode_q),
    .comm_we(comm_we), .comm_wdata(comm_wdata), .comm_q(comm_q)
  );

  function automatic int f_single(int idx, bit ext, logic [31:0] md);
    int p = idx;
    if (ext) p = p ^ 16;
    if (md[21]) p = p ^ 16;
    return p;
  endfunction

  function automatic int f_pair(int idx, logic [31:0] md);
    int n = idx;
    if (md[20] && (n % 2 == 1)) n = n + 15;
    if (md[21]) n = n ^ 16;
    return (n / 2) * 2;
  endfunction

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Behavioural reference: updated at each rising edge from the sampled inputs.
  always @(posedge clk) begin
    int sa;
    int pa;
    if (rst) begin
      for (int i = 0; i < 32; i++) m_reg[i] = 32'h0;
      m_mode = 32'h0004_0001 & MASK;
      m_comm = 32'h0;
    end else begin
      sa = f_single(int'(sw_idx), sw_ext, m_mode);
      pa = f_pair(int'(pw_idx), m_mode);
      if (sw_we) m_reg[sa] = sw_data;
      if (pw_we) begin
        m_reg[pa]     = pw_data[63:32];
        m_reg[pa + 1] = pw_data[31:0];
      end
      if (comm_we) m_comm = comm_wdata;
      if (mode_we) m_mode = mode_wdata & MASK;
      else if (tog_en) begin
        if (tog_sel == 2'd0) m_mode[20] = ~m_mode[20];
        else if (tog_sel == 2'd1) m_mode[19] = ~m_mode[19];
        else if (tog_sel == 2'd2) m_mode[21] = ~m_mode[21];
      end
    end
  end

  // Every-cycle comparison against the reference, away from the rising edge.
  always @(negedge clk) begin
    if (run_cmp) begin
      chk({32'h0, sr_data}, {32'h0, m_reg[f_single(int'(sr_idx), sr_ext, m_mode)]},
          "R2 R3 R7 R8 single read vs model");
      chk(pr_data, {m_reg[f_pair(int'(pr_idx), m_mode)], m_reg[f_pair(int'(pr_idx), m_mode) + 1]},
          "R4 R5 R6 pair read vs model");
      chk({32'h0, mode_q}, {32'h0, m_mode}, "R9 R10 R11 mode vs model");
      chk({32'h0, comm_q}, {32'h0, m_comm}, "R12 comm vs model");
    end
  end

  task automatic idle();
    sw_we = 1'b0; pw_we = 1'b0; mode_we = 1'b0; tog_en = 1'b0; comm_we = 1'b0;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    idle();
  endtask

  task automatic toggle(input logic [1:0] s);
    tog_en = 1'b1;
    tog_sel = s;
    tick();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog all requirements act=hang exp=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    idle();
    sw_idx = 0; sw_ext = 0; sw_data = 0; sr_idx = 0; sr_ext = 0;
    pw_idx = 0; pw_data = 0; pr_idx = 0; mode_wdata = 0; tog_sel = 0; comm_wdata = 0;
    repeat (3) @(posedge clk);
    #1;
    run_cmp = 1'b1;
    // R1: reset state of every entry, mode and comm
    for (int i = 0; i < 32; i++) begin
      sr_idx = 4'(i);
      sr_ext = (i >= 16);
      #1;
      chk({32'h0, sr_data}, 64'h0, "R1 entry cleared");
    end
    chk({32'h0, mode_q}, 64'h0004_0001, "R1 mode init");
    chk({32'h0, comm_q}, 64'h0, "R1 comm cleared");
    @(posedge clk);
    #1;
    rst = 1'b0;

    // R7: old value visible during the write cycle, new value after the edge
    sw_we = 1'b1; sw_idx = 4'd2; sw_ext = 1'b0; sw_data = 32'hAAAA_0002;
    sr_idx = 4'd2; sr_ext = 1'b0;
    @(negedge clk);
    chk({32'h0, sr_data}, 64'h0, "R7 read before edge");
    tick();
    #1;
    chk({32'h0, sr_data}, 64'hAAAA_0002, "R7 read after edge");

    // R2 R3: write through bank 1, read back with the extended flag from bank 0
    toggle(2'd2);
    sw_we = 1'b1; sw_idx = 4'd3; sw_ext = 1'b0; sw_data = 32'h0000_0013;
    tick();
    toggle(2'd2);
    sr_idx = 4'd3; sr_ext = 1'b1;
    #1;
    chk({32'h0, sr_data}, 64'h13, "R3 extended read reaches entry 19");
    sr_ext = 1'b0;
    #1;
    chk({32'h0, sr_data}, 64'h0, "R2 bank 0 entry 3 untouched");

    // R5 R4 R6: odd pair number in 64-bit mode lands in the opposite bank
    toggle(2'd0);
    pw_we = 1'b1; pw_idx = 4'd5; pw_data = 64'h5A5A_0000_5A5A_0001;
    tick();
    pr_idx = 4'd5;
    #1;
    chk(pr_data, 64'h5A5A_0000_5A5A_0001, "R5 pair read of redirected pair");
    toggle(2'd0);
    #1;
    chk(pr_data, 64'h0, "R4 odd number rounds down to entries 4 and 5");
    sr_idx = 4'd4; sr_ext = 1'b1;
    #1;
    chk({32'h0, sr_data}, 64'h5A5A_0000, "R6 even entry holds high half");
    sr_idx = 4'd5;
    #1;
    chk({32'h0, sr_data}, 64'h5A5A_0001, "R6 odd entry holds low half");

    // R8: same-cycle collision, pair write wins
    pw_we = 1'b1; pw_idx = 4'd6; pw_data = 64'h0000_C0C0_0000_D0D0;
    sw_we = 1'b1; sw_idx = 4'd7; sw_ext = 1'b0; sw_data = 32'h0000_EEEE;
    tick();
    sr_idx = 4'd7; sr_ext = 1'b0;
    #1;
    chk({32'h0, sr_data}, 64'hD0D0, "R8 pair beats single on entry 7");

    // R9: upper bits masked
    mode_we = 1'b1; mode_wdata = 32'hFFFF_FFFF;
    tick();
    #1;
    chk({32'h0, mode_q}, 64'h003F_FFFF, "R9 upper mode bits read zero");
    mode_we = 1'b1; mode_wdata = 32'h0004_0001;
    tick();

    // R10: precision toggled twice restores, select 3 does nothing
    toggle(2'd1);
    #1;
    chk({32'h0, mode_q}, 64'h000C_0001, "R10 precision toggled");
    toggle(2'd1);
    #1;
    chk({32'h0, mode_q}, 64'h0004_0001, "R10 second toggle restores");
    toggle(2'd3);
    #1;
    chk({32'h0, mode_q}, 64'h0004_0001, "R10 select 3 no effect");

    // R11: write beats toggle
    mode_we = 1'b1; mode_wdata = 32'h0000_0002; tog_en = 1'b1; tog_sel = 2'd2;
    tick();
    #1;
    chk({32'h0, mode_q}, 64'h2, "R11 write wins over toggle");

    // R12: load then hold while other ports are busy
    comm_we = 1'b1; comm_wdata = 32'hCAFE_BABE;
    tick();
    for (int k = 0; k < 3; k++) begin
      sw_we = 1'b1; sw_data = 32'h1234_0000 + 32'(k);
      mode_we = 1'b1; mode_wdata = 32'h00FF_0000;
      comm_wdata = 32'h0BAD_0000;
      tick();
    end
    #1;
    chk({32'h0, comm_q}, 64'hCAFE_BABE, "R12 comm holds");

    // Random traffic, checked every cycle against the model
    repeat (3000) begin
      @(posedge clk);
      #1;
      sw_we      = ($urandom % 2) == 0;
      sw_idx     = 4'($urandom);
      sw_ext     = 1'($urandom);
      sw_data    = $urandom;
      pw_we      = ($urandom % 3) == 0;
      pw_idx     = 4'($urandom);
      pw_data    = {$urandom, $urandom};
      sr_idx     = 4'($urandom);
      sr_ext     = 1'($urandom);
      pr_idx     = 4'($urandom);
      mode_we    = ($urandom % 10) == 0;
      mode_wdata = $urandom;
      tog_en     = ($urandom % 4) == 0;
      tog_sel    = 2'($urandom);
      comm_we    = ($urandom % 5) == 0;
      comm_wdata = $urandom;
    end
    tick();
    @(negedge clk);
    run_cmp = 1'b0;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule